// File: doc/BRIEF.md
# PHY Error Statistics Counter Bank

This block keeps four read-only error statistics for an Ethernet PHY and one small control register that chooses what two LED outputs show. The error detectors elsewhere in the PHY report one-cycle event pulses. For receive symbol errors they report one flag per received symbol and a level that is high while a frame is in progress. A management agent reads the counters through a simple register port: an address, a read strobe, a write strobe, write data and a combinational read-data output.

Each counter is 16 bits wide. It saturates at all ones and returns to zero as a side effect of being read. The symbol error counter groups runs of bad symbols inside a frame, so six consecutive bad symbols add a single count. The 100BASE-TX premature end-of-frame input is pulsed once for each frame that ends without its end-of-stream delimiter pair.

The control register holds a three-bit LED mode. In each mode the two LED pins either follow PHY status inputs (activity, speed, link, collision) or are forced to a fixed level.

Top module: `phy_err_stats`

## Requirements
- R1: After reset every counter reads 0x0000 and the LED mode reads 000.
- R2: A counter that holds 0xFFFF stays at 0xFFFF on further events and never wraps to zero.
- R3: While `rd_en` is high, `rdata` shows the addressed register in the same cycle. A read of a counter clears it to zero at the following clock edge.
- R4: If an event for a counter arrives in the same cycle that counter is read, the read returns the old value and the counter holds 1 afterwards.
- R5: While `in_frame` is high, the first bad symbol of a run adds one to the symbol counter and the next five consecutive bad symbols add nothing. A good symbol, or `in_frame` going low, restarts the grouping, so a partial group counts once. Bad symbols flagged while `in_frame` is low are not counted.
- R6: The counters sit at fixed addresses: 22 holds symbol errors, 23 holds 100BASE-TX premature end-of-frame events (`peof_evt`), 24 holds 10BASE-T end-of-frame errors (`eof_err_evt`) and 25 holds jabber detections (`jabber_evt`).
- R7: Register 27 stores `wdata[2:0]` as the LED mode when `wr_en` is high. Its bits 15:3 always read zero and ignore writes.
- R8: The mode codes set (`led_a`, `led_b`) as follows: 000 gives (activity, link), 001 gives (speed, collision), 010 gives (speed, link), 011 gives (activity, collision), 100 gives (0,0), 101 gives (0,1), 110 gives (1,0) and 111 gives (1,1). The LEDs follow a new mode from the cycle after the write.
- R9: A read of any address other than 22–25 and 27 returns zero and changes no counter. A write to any address other than 27 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | A received symbol is present this cycle |
| sym_bad | input | 1 | The present symbol is invalid |
| in_frame | input | 1 | A receive frame is in progress |
| peof_evt | input | 1 | 100BASE-TX premature end-of-frame pulse |
| eof_err_evt | input | 1 | 10BASE-T end-of-frame error pulse |
| jabber_evt | input | 1 | 10BASE-T transmit jabber pulse |
| st_activity | input | 1 | Activity status for LEDs |
| st_speed | input | 1 | Speed status for LEDs |
| st_link | input | 1 | Link status for LEDs |
| st_collision | input | 1 | Collision status for LEDs |
| addr | input | 5 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero when `rd_en` is low |
| led_a | output | 1 | First LED drive |
| led_b | output | 1 | Second LED drive |

## Verification
The symbol counter is driven with runs of exactly six, seven and twelve bad symbols, with a run broken by a good symbol, and with a run broken by the end of a frame. Together these separate correct grouping from counting every bad symbol and from never restarting a group. Bad symbols outside a frame show whether the frame gate is applied. An event held high through a read checks that no event is lost at the clear. A run of more than 65,535 events shows saturation as opposed to wrapping. Each LED mode is tried with two opposite status patterns, which tells a status-following mode apart from a forced level.

// File: rtl/phy_err_stats.sv
module phy_err_stats #(
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 5,
  parameter int GROUP_LEN = 6,
  parameter int MODE_W    = 3,
  parameter int ADR_BASE  = 22,
  parameter int ADR_CTL   = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid,
  input  logic              sym_bad,
  input  logic              in_frame,
  input  logic              peof_evt,
  input  logic              eof_err_evt,
  input  logic              jabber_evt,
  input  logic              st_activity,
  input  logic              st_speed,
  input  logic              st_link,
  input  logic              st_collision,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              led_a,
  output logic              led_b
);
  localparam int NCNT = 4;
  localparam int GRP_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  cnt [NCNT];
  logic [NCNT-1:0]   evt, rd_hit;
  logic [GRP_W-1:0]  grp;
  logic [MODE_W-1:0] mode;
  logic              sym_take, sym_hit, ctl_hit, unmapped;

  wire unused_wdata = ^wdata[DATA_W-1:MODE_W];

  assign sym_take = sym_valid && sym_bad && in_frame;
  assign sym_hit  = sym_take && (grp == '0);
  assign evt      = {jabber_evt, eof_err_evt, peof_evt, sym_hit};
  assign ctl_hit  = (addr == ADDR_W'(ADR_CTL));
  assign unmapped = !ctl_hit && (rd_hit == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !in_frame || (sym_valid && !sym_bad))
      grp <= '0;
    else if (sym_take)
      grp <= (grp == GRP_W'(GROUP_LEN - 1)) ? '0 : grp + 1'b1;
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    assign rd_hit[g] = rd_en && (addr == ADDR_W'(ADR_BASE + g));
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[g] <= '0;
      else if (rd_hit[g])
        cnt[g] <= CNT_W'(evt[g]);
      else if (evt[g] && cnt[g] != CNT_MAX)
        cnt[g] <= cnt[g] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode <= '0;
    else if (wr_en && ctl_hit)
      mode <= wdata[MODE_W-1:0];
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (ctl_hit) rdata = DATA_W'(mode);
      for (int i = 0; i < NCNT; i++)
        if (rd_hit[i]) rdata = DATA_W'(cnt[i]);
    end
  end

  always_comb begin
    case (mode)
      3'b000:  {led_a, led_b} = {st_activity, st_link};
      3'b001:  {led_a, led_b} = {st_speed, st_collision};
      3'b010:  {led_a, led_b} = {st_speed, st_link};
      3'b011:  {led_a, led_b} = {st_activity, st_collision};
      default: {led_a, led_b} = mode[1:0];
    endcase
  end

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(ADR_BASE + 3) && !jabber_evt) |=> (cnt[3] == '0));

  a_r4_read_keeps_event: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(ADR_BASE + 1) && peof_evt) |=> (cnt[1] == CNT_W'(1)));

  a_r2_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[3] == CNT_MAX && !(rd_en && addr == ADDR_W'(ADR_BASE + 3))) |=> (cnt[3] == CNT_MAX));

  a_r5_group_absorbs: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_take && grp != '0 && !(rd_en && addr == ADDR_W'(ADR_BASE))) |=> $stable(cnt[0]));

  a_r8_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b100) |-> (!led_a && !led_b));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |-> (rdata == '0));
endmodule

// File: tb/phy_err_stats_bench.sv
`timescale 1ns/1ps
module phy_err_stats_bench;
  logic clk = 0, rst_n = 0;
  logic sym_valid = 0, sym_bad = 0, in_frame = 0;
  logic peof_evt = 0, eof_err_evt = 0, jabber_evt = 0;
  logic st_activity = 0, st_speed = 0, st_link = 0, st_collision = 0;
  logic [4:0] addr = '0;
  logic rd_en = 0, wr_en = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic led_a, led_b;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  phy_err_stats u_phy_err_stats (
    .clk, .rst_n, .sym_valid, .sym_bad, .in_frame, .peof_evt, .eof_err_evt,
    .jabber_evt, .st_activity, .st_speed, .st_link, .st_collision,
    .addr, .rd_en, .wr_en, .wdata, .rdata, .led_a, .led_b);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [4:0] a, logic [15:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; rd_en = 1; tick(); rd_en = 0;
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    addr = a; wdata = d; wr_en = 1; tick(); wr_en = 0;
  endtask

  task automatic sym(logic bad);
    sym_valid = 1; sym_bad = bad; tick(); sym_valid = 0; sym_bad = 0;
  endtask

  task automatic bad_run(int n);
    for (int i = 0; i < n; i++) sym(1);
  endtask

  task automatic frame_gap();
    in_frame = 0; tick(); in_frame = 1;
  endtask

  always @(negedge clk) if (rd_en) begin
    if (exp_q.size() == 0) chk("scoreboard empty", rdata, 16'hxxxx);
    else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  function automatic logic [1:0] led_exp(logic [2:0] m, logic ac, logic sp, logic lk, logic co);
    case (m)
      3'd0: return {ac, lk};
      3'd1: return {sp, co};
      3'd2: return {sp, lk};
      3'd3: return {ac, co};
      3'd4: return 2'b00;
      3'd5: return 2'b01;
      3'd6: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    for (int a = 22; a <= 25; a++) rd(5'(a), 16'h0000, "R1 counter after reset");
    rd(5'd27, 16'h0000, "R1 mode after reset");
    st_activity = 1; st_link = 0; #1;
    chk("R1 led default mode", {14'd0, led_a, led_b}, 16'h0002);
    st_activity = 0;

    // R6 address map
    repeat (3) begin peof_evt = 1; tick(); peof_evt = 0; tick(); end
    repeat (2) begin eof_err_evt = 1; tick(); eof_err_evt = 0; end
    jabber_evt = 1; tick(); jabber_evt = 0;
    rd(5'd23, 16'd3, "R6 premature eof count");
    rd(5'd25, 16'd1, "R6 jabber count");
    // R3 clear on read
    rd(5'd23, 16'd0, "R3 cleared after read");

    // R4 event coincident with read
    eof_err_evt = 1; addr = 5'd24;
    rd(5'd24, 16'd2, "R4 old value returned");
    eof_err_evt = 0;
    rd(5'd24, 16'd1, "R4 event kept");

    // R5 symbol grouping
    in_frame = 1;
    bad_run(6); frame_gap();
    rd(5'd22, 16'd1, "R5 six bad");
    bad_run(7); frame_gap();
    rd(5'd22, 16'd2, "R5 seven bad");
    bad_run(12); frame_gap();
    rd(5'd22, 16'd2, "R5 twelve bad");
    sym(1); sym(1); sym(0); sym(1); frame_gap();
    rd(5'd22, 16'd2, "R5 good symbol restarts");
    bad_run(3); frame_gap(); bad_run(2); frame_gap();
    rd(5'd22, 16'd2, "R5 frame end restarts");
    in_frame = 0;
    bad_run(4);
    rd(5'd22, 16'd0, "R5 outside frame ignored");

    // R9 unmapped
    peof_evt = 1; tick(); peof_evt = 0;
    wr(5'd26, 16'hFFFF);
    wr(5'd23, 16'h1234);
    rd(5'd20, 16'd0, "R9 unmapped read 20");
    rd(5'd31, 16'd0, "R9 unmapped read 31");
    rd(5'd23, 16'd1, "R9 counter untouched");
    rd(5'd27, 16'd0, "R9 mode untouched by stray write");

    // R7 control register
    wr(5'd27, 16'hFFFD);
    rd(5'd27, 16'h0005, "R7 reserved bits zero");

    // R8 LED modes with two opposite status patterns
    for (int m = 0; m < 8; m++) begin
      wr(5'd27, 16'(m));
      {st_activity, st_speed, st_link, st_collision} = 4'b1010; #1;
      chk($sformatf("R8 mode %0d pattern A", m), {14'd0, led_a, led_b},
          {14'd0, led_exp(3'(m), 1, 0, 1, 0)});
      {st_activity, st_speed, st_link, st_collision} = 4'b0101; #1;
      chk($sformatf("R8 mode %0d pattern B", m), {14'd0, led_a, led_b},
          {14'd0, led_exp(3'(m), 0, 1, 0, 1)});
    end

    // R2 saturation
    jabber_evt = 1;
    repeat (70000) tick();
    jabber_evt = 0;
    rd(5'd25, 16'hFFFF, "R2 saturated");
    rd(5'd25, 16'h0000, "R3 cleared after saturation");

    tick();
    if (exp_q.size() != 0) chk("scoreboard drained", 16'(exp_q.size()), 16'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule